// File: doc/BRIEF.md
# Priority Peripheral-to-Pin Crossbar

This combinational allocator decides which peripheral output drives each of 32 general-purpose pins, grouped as four ports of eight. Pins are numbered from port 0 pin 0 (index 0) up to port 3 pin 7 (index 31). Each peripheral group has its own enable. The allocator walks the enabled signals in a fixed rank and gives each one the lowest-numbered pin that is still free. A pin is not free if its bit in the 32-bit skip mask is set, if it does not exist in the selected package, or if it is already taken.

UART0 is the exception. Its two lines always sit on port 0 pins 4 and 5, and those two pins are kept out of the walk while UART0 is on. The SMBus and UART1 lines are always requested in pairs. The SPI chip-select line is requested only in four-wire mode. When the small package is selected, pins 25 to 31 do not exist and UART1 cannot be requested.

Every pin that gets no signal stays ordinary port I/O. Any requested signal that cannot be placed is dropped and flagged. The configuration inputs are expected to come from registers elsewhere in the chip.

Top module: `xbar_top`

## Requirements
- R1: Enabled signals other than UART0 are placed in rank order, each on the lowest-index free pin. The ranks and their source codes are: SPI clock 3, SPI data-in 4, SPI data-out 5, SPI chip-select 6, SMBus data 7, SMBus clock 8, comparator 0 sync 9, comparator 0 async 10, comparator 1 sync 11, comparator 1 async 12, system clock 13, PCA channels 0 to 4 as codes 14 to 18, PCA external clock 19, timer 0 20, timer 1 21, UART1 transmit 22, UART1 receive 23.
- R2: A pin whose bit is set in `skip_mask` (bit n is pin n) never carries a walked signal. The walk moves on to the next free pin.
- R3: Enabling the SMBus requests both of its lines. Enabling UART1 requests both of its lines.
- R4: While `uart0_en` is 1, pin 4 carries code 1 (transmit) and pin 5 carries code 2 (receive), even when their skip bits are set. No other signal uses those two pins. While `uart0_en` is 0, pins 4 and 5 are free like any other pin.
- R5: Code 6 (SPI chip-select) is requested only when `spi_en` and `spi_4wire` are both 1.
- R6: With `small_pkg` at 1, pins 25 to 31 carry no signal. In that case `uart1_en` has no effect: UART1 gets no pin and raises no drop flag.
- R7: A pin with no signal reads code 0 with `pin_periph` low. `pin_periph[n]` is 1 exactly when pin n carries a nonzero code.
- R8: A requested signal that finds no free pin sets bit (code−1) of `sig_drop`, and `any_drop` goes high.
- R9: `pca_chan` = n enables PCA channels 0 to n−1. Values of 5 or more enable all five channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| uart0_en | input | 1 | UART0 enable (fixed pins) |
| spi_en | input | 1 | SPI enable |
| spi_4wire | input | 1 | 1 selects four-wire SPI |
| smbus_en | input | 1 | SMBus enable |
| cmp_en | input | 4 | Comparator outputs: bit0 cmp0 sync, bit1 cmp0 async, bit2 cmp1 sync, bit3 cmp1 async |
| sysclk_en | input | 1 | System clock output enable |
| pca_chan | input | 3 | Number of PCA channels routed |
| eci_en | input | 1 | PCA external clock input enable |
| tmr_en | input | 2 | bit0 timer 0, bit1 timer 1 |
| uart1_en | input | 1 | UART1 enable |
| skip_mask | input | 32 | Pins excluded from the walk |
| small_pkg | input | 1 | 1 selects the 25-pin package |
| pin_src | output | 160 | 5-bit source code per pin, pin n at bits [5n+4:5n] |
| pin_periph | output | 32 | Pin carries a peripheral |
| sig_drop | output | 23 | Per-signal overflow, bit = code−1 |
| any_drop | output | 1 | Some requested signal was dropped |

## Verification
The walk and the fixed UART0 placement both act on port 0 pins 4 and 5 in the same evaluation. Overflow and the package limit can also strike in the same evaluation. The bench turns UART0 on with enough walked signals that the walk has to jump over pins 4 and 5, and it also sets skip bits on those pins to show that the fixed placement wins. It then limits the free pins to the high end in the small package and checks that only the walked signal is flagged as dropped while UART1 stays silent. Each case is judged against pin codes worked out by hand.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int NUM_PINS    = 32;
  localparam int SMALL_PINS  = 25;
  localparam int NUM_SIG     = 23;
  localparam int CODE_W      = $clog2(NUM_SIG + 1);
  localparam int NUM_CEX     = 5;
  localparam int TX0_PIN     = 4;
  localparam int RX0_PIN     = 5;
  // rank indices; source code = rank + 1
  localparam int S_TX0  = 0;
  localparam int S_RX0  = 1;
  localparam int S_SCK  = 2;
  localparam int S_MISO = 3;
  localparam int S_MOSI = 4;
  localparam int S_NSS  = 5;
  localparam int S_SDA  = 6;
  localparam int S_SCL  = 7;
  localparam int S_CMP  = 8;   // four comparator outputs from here
  localparam int S_SYSC = 12;
  localparam int S_CEX0 = 13;
  localparam int S_ECI  = 18;
  localparam int S_T0   = 19;
  localparam int S_T1   = 20;
  localparam int S_TX1  = 21;
  localparam int S_RX1  = 22;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/xbar_req_decode.sv
module xbar_req_decode
  import xbar_pkg::*;
(
  input  logic               spi_en,
  input  logic               spi_4wire,
  input  logic               smbus_en,
  input  logic [3:0]         cmp_en,
  input  logic               sysclk_en,
  input  logic [2:0]         pca_chan,
  input  logic               eci_en,
  input  logic [1:0]         tmr_en,
  input  logic               uart1_en,
  input  logic               small_pkg,
  output logic [NUM_SIG-1:0] req
);
  always_comb begin
    req          = '0;
    req[S_SCK]   = spi_en;
    req[S_MISO]  = spi_en;
    req[S_MOSI]  = spi_en;
    req[S_NSS]   = spi_en & spi_4wire;
    req[S_SDA]   = smbus_en;
    req[S_SCL]   = smbus_en;
    for (int c = 0; c < 4; c++) req[S_CMP + c] = cmp_en[c];
    req[S_SYSC]  = sysclk_en;
    for (int c = 0; c < NUM_CEX; c++) req[S_CEX0 + c] = (int'(pca_chan) > c);
    req[S_ECI]   = eci_en;
    req[S_T0]    = tmr_en[0];
    req[S_T1]    = tmr_en[1];
    req[S_TX1]   = uart1_en & ~small_pkg;
    req[S_RX1]   = uart1_en & ~small_pkg;
  end
endmodule

// File: rtl/xbar_pin_avail.sv
module xbar_pin_avail
  import xbar_pkg::*;
(
  input  logic [NUM_PINS-1:0] skip_mask,
  input  logic                small_pkg,
  input  logic                uart0_en,
  output logic [NUM_PINS-1:0] free
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    if (p >= SMALL_PINS) begin : g_hi
      assign free[p] = ~skip_mask[p] & ~small_pkg;
    end else if (p == TX0_PIN || p == RX0_PIN) begin : g_u0
      assign free[p] = ~skip_mask[p] & ~uart0_en;
    end else begin : g_std
      assign free[p] = ~skip_mask[p];
    end
  end
endmodule

// File: rtl/xbar_alloc.sv
module xbar_alloc
  import xbar_pkg::*;
(
  input  logic [NUM_SIG-1:0]  req,
  input  logic [NUM_PINS-1:0] free,
  output code_t               code [NUM_PINS],
  output logic [NUM_SIG-1:0]  drop
);
  logic [NUM_PINS-1:0] open_q;
  logic                found;

  always_comb begin
    open_q = free;
    drop   = '0;
    found  = 1'b0;
    for (int p = 0; p < NUM_PINS; p++) code[p] = '0;
    for (int s = 0; s < NUM_SIG; s++) begin
      if (req[s]) begin
        found = 1'b0;
        for (int p = 0; p < NUM_PINS; p++) begin
          if (!found && open_q[p]) begin
            found     = 1'b1;
            open_q[p] = 1'b0;
            code[p]   = code_t'(s + 1);
          end
        end
        if (!found) drop[s] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xbar_top.sv
module xbar_top
  import xbar_pkg::*;
(
  input  logic                       uart0_en,
  input  logic                       spi_en,
  input  logic                       spi_4wire,
  input  logic                       smbus_en,
  input  logic [3:0]                 cmp_en,
  input  logic                       sysclk_en,
  input  logic [2:0]                 pca_chan,
  input  logic                       eci_en,
  input  logic [1:0]                 tmr_en,
  input  logic                       uart1_en,
  input  logic [31:0]                skip_mask,
  input  logic                       small_pkg,
  output logic [32*CODE_W-1:0]       pin_src,
  output logic [31:0]                pin_periph,
  output logic [NUM_SIG-1:0]         sig_drop,
  output logic                       any_drop
);
  logic [NUM_SIG-1:0]  req;
  logic [NUM_PINS-1:0] free;
  code_t               walk_code [NUM_PINS];

  xbar_req_decode u_req (
    .spi_en(spi_en), .spi_4wire(spi_4wire), .smbus_en(smbus_en),
    .cmp_en(cmp_en), .sysclk_en(sysclk_en), .pca_chan(pca_chan),
    .eci_en(eci_en), .tmr_en(tmr_en), .uart1_en(uart1_en),
    .small_pkg(small_pkg), .req(req)
  );

  xbar_pin_avail u_avail (
    .skip_mask(skip_mask), .small_pkg(small_pkg),
    .uart0_en(uart0_en), .free(free)
  );

  xbar_alloc u_alloc (
    .req(req), .free(free), .code(walk_code), .drop(sig_drop)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_out
    code_t final_code;
    if (p == TX0_PIN) begin : g_tx0
      assign final_code = uart0_en ? code_t'(S_TX0 + 1) : walk_code[p];
    end else if (p == RX0_PIN) begin : g_rx0
      assign final_code = uart0_en ? code_t'(S_RX0 + 1) : walk_code[p];
    end else begin : g_walk
      assign final_code = walk_code[p];
    end
    assign pin_src[p*CODE_W +: CODE_W] = final_code;
    assign pin_periph[p] = |final_code;
  end

  assign any_drop = |sig_drop;
endmodule

// File: rtl/xbar_chk.sv
module xbar_chk
  import xbar_pkg::*;
(
  input logic                 uart0_en,
  input logic                 spi_en,
  input logic                 spi_4wire,
  input logic [31:0]          skip_mask,
  input logic                 small_pkg,
  input logic [32*CODE_W-1:0] pin_src,
  input logic [31:0]          pin_periph,
  input logic [NUM_SIG-1:0]   sig_drop,
  input logic                 any_drop
);
  logic [31:0] u0_pins;
  logic [31:0] usable;
  assign u0_pins = uart0_en ? (32'b1 << TX0_PIN) | (32'b1 << RX0_PIN) : 32'b0;
  assign usable  = ~skip_mask & (small_pkg ? 32'h01FF_FFFF : 32'hFFFF_FFFF);

  always_comb begin
    // R2
    skip_respected_chk: assert ((pin_periph & skip_mask & ~u0_pins) == 32'b0);
    // R6
    small_pkg_chk: assert (!small_pkg ||
      (pin_periph[31:25] == 7'b0 && sig_drop[S_TX1] == 1'b0 && sig_drop[S_RX1] == 1'b0));
    // R4
    uart0_fixed_chk: assert (!uart0_en ||
      (pin_src[TX0_PIN*CODE_W +: CODE_W] == CODE_W'(S_TX0 + 1) &&
       pin_src[RX0_PIN*CODE_W +: CODE_W] == CODE_W'(S_RX0 + 1)));
    // R8
    drop_full_chk: assert (!any_drop || ((usable & ~pin_periph) == 32'b0));
    for (int p = 0; p < 32; p++) begin
      // R5
      nss_mode_chk: assert ((spi_en && spi_4wire) ||
        pin_src[p*CODE_W +: CODE_W] != CODE_W'(S_NSS + 1));
    end
  end
endmodule

bind xbar_top xbar_chk u_chk (
  .uart0_en(uart0_en), .spi_en(spi_en), .spi_4wire(spi_4wire),
  .skip_mask(skip_mask), .small_pkg(small_pkg), .pin_src(pin_src),
  .pin_periph(pin_periph), .sig_drop(sig_drop), .any_drop(any_drop)
);

// File: tb/sim_xbar_top.sv
module sim_xbar_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 5;

  logic clk;
  logic rst_n;
  logic uart0_en, spi_en, spi_4wire, smbus_en, sysclk_en, eci_en, uart1_en, small_pkg;
  logic [3:0]  cmp_en;
  logic [2:0]  pca_chan;
  logic [1:0]  tmr_en;
  logic [31:0] skip_mask;
  logic [32*CW-1:0] pin_src;
  logic [31:0] pin_periph;
  logic [22:0] sig_drop;
  logic        any_drop;
  int checks = 0;
  int errors = 0;

  xbar_top u0 (
    .uart0_en(uart0_en), .spi_en(spi_en), .spi_4wire(spi_4wire),
    .smbus_en(smbus_en), .cmp_en(cmp_en), .sysclk_en(sysclk_en),
    .pca_chan(pca_chan), .eci_en(eci_en), .tmr_en(tmr_en),
    .uart1_en(uart1_en), .skip_mask(skip_mask), .small_pkg(small_pkg),
    .pin_src(pin_src), .pin_periph(pin_periph), .sig_drop(sig_drop),
    .any_drop(any_drop)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic clear_cfg();
    uart0_en = 0; spi_en = 0; spi_4wire = 0; smbus_en = 0; sysclk_en = 0;
    eci_en = 0; uart1_en = 0; small_pkg = 0; cmp_en = '0; pca_chan = '0;
    tmr_en = '0; skip_mask = '0;
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_pin(input int pin, input int exp_code, input string rq);
    int act;
    act = int'(pin_src[pin*CW +: CW]);
    checks++;
    if (act != exp_code || pin_periph[pin] != (exp_code != 0)) begin
      errors++;
      $display("FAIL %s pin %0d code act=%0d exp=%0d periph act=%0b", rq, pin, act,
               exp_code, pin_periph[pin]);
    end
  endtask

  task automatic chk_drop(input logic [22:0] exp, input string rq);
    checks++;
    if (sig_drop != exp || any_drop != (exp != 0)) begin
      errors++;
      $display("FAIL %s drop act=%h/%0b exp=%h", rq, sig_drop, any_drop, exp);
    end
  endtask

  task automatic chk_range_idle(input int lo, input int hi, input string rq);
    for (int p = lo; p <= hi; p++) chk_pin(p, 0, rq);
  endtask

  task automatic t_idle();
    clear_cfg(); settle();
    chk_range_idle(0, 31, "R7");
    chk_drop('0, "R8");
  endtask

  task automatic t_uart0_three_wire();
    clear_cfg(); uart0_en = 1; spi_en = 1; smbus_en = 1; settle();
    chk_pin(0, 3, "R1"); chk_pin(1, 4, "R1"); chk_pin(2, 5, "R1");
    chk_pin(3, 7, "R3"); chk_pin(4, 1, "R4"); chk_pin(5, 2, "R4");
    chk_pin(6, 8, "R3"); chk_pin(7, 0, "R5"); chk_drop('0, "R8");
  endtask

  task automatic t_four_wire();
    clear_cfg(); uart0_en = 1; spi_en = 1; spi_4wire = 1; smbus_en = 1; settle();
    chk_pin(3, 6, "R5"); chk_pin(6, 7, "R5"); chk_pin(7, 8, "R5"); chk_pin(8, 0, "R7");
  endtask

  task automatic t_crystal_skip();
    clear_cfg(); uart0_en = 1; spi_en = 1; spi_4wire = 1;
    skip_mask = 32'h0000_000C; settle();
    chk_pin(0, 3, "R2"); chk_pin(1, 4, "R2"); chk_pin(2, 0, "R2"); chk_pin(3, 0, "R2");
    chk_pin(6, 5, "R2"); chk_pin(7, 6, "R2");
  endtask

  task automatic t_uart0_skipped();
    clear_cfg(); uart0_en = 1; skip_mask = 32'h0000_0030; settle();
    chk_pin(4, 1, "R4"); chk_pin(5, 2, "R4");
    clear_cfg(); cmp_en = 4'hF; sysclk_en = 1; settle();
    chk_pin(0, 9, "R4"); chk_pin(3, 12, "R4"); chk_pin(4, 13, "R4"); chk_pin(5, 0, "R4");
  endtask

  task automatic t_pca();
    clear_cfg(); pca_chan = 3'd7; settle();
    for (int p = 0; p < 5; p++) chk_pin(p, 14 + p, "R9");
    chk_pin(5, 0, "R9");
    clear_cfg(); pca_chan = 3'd2; settle();
    chk_pin(0, 14, "R9"); chk_pin(1, 15, "R9"); chk_pin(2, 0, "R9");
  endtask

  task automatic t_small_pkg();
    clear_cfg(); small_pkg = 1; uart1_en = 1; tmr_en = 2'b11;
    skip_mask = 32'h00FF_FFFF; settle();
    chk_pin(24, 20, "R6"); chk_range_idle(25, 31, "R6");
    chk_drop(23'h1 << 20, "R8");
    small_pkg = 0; settle();
    chk_pin(24, 20, "R3"); chk_pin(25, 21, "R3"); chk_pin(26, 22, "R3");
    chk_pin(27, 23, "R3"); chk_drop('0, "R3");
  endtask

  task automatic t_overflow();
    clear_cfg(); smbus_en = 1; skip_mask = 32'hFFFF_FFFE; settle();
    chk_pin(0, 7, "R8"); chk_drop(23'h1 << 7, "R8");
  endtask

  task automatic t_full_order();
    clear_cfg(); uart0_en = 1; spi_en = 1; spi_4wire = 1; smbus_en = 1;
    cmp_en = 4'hF; sysclk_en = 1; pca_chan = 3'd5; eci_en = 1; tmr_en = 2'b11;
    uart1_en = 1; settle();
    for (int p = 0; p < 4; p++) chk_pin(p, 3 + p, "R1");
    for (int p = 6; p < 23; p++) chk_pin(p, p + 1, "R1");
    chk_range_idle(23, 31, "R7"); chk_drop('0, "R1");
  endtask

  initial begin
    clear_cfg();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_uart0_three_wire();
    t_four_wire();
    t_crystal_skip();
    t_uart0_skipped();
    t_pca();
    t_small_pkg();
    t_overflow();
    t_full_order();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule